// File: doc/BRIEF.md
# Rename-Stage Move and Swap Eliminator

This block sits in the rename stage and decides whether a register copy (one write fed by one read) or a register exchange (two writes fed by two reads) can be dropped from execution. A copy that is dropped gets no new physical register. Its destination is recorded as an alias of the value the source currently names. The block keeps an alias table and a known-zero bit per architectural register. It also keeps one elimination counter per register file, so that only a fixed number of eliminations is accepted in each rename cycle.

A request carries the read and write counts, the register indexes, and the owning file of each operand. For each write it also carries whether its register class permits elimination and whether it is a partial write that leaves the upper part of its containing register intact. A request flagged as a plain write does not eliminate anything. It only updates the table entry of its destination. The first request of each rename cycle is flagged, and that flag clears the per-file counters. A lookup port shows the table entry of any register.

Each request goes through a three-state control sequence. IDLE accepts a request (IDLE→EVAL when `req_valid`). EVAL evaluates the request and commits the table and counter updates (EVAL→DONE, unconditional). DONE presents the result for one cycle (DONE→IDLE, unconditional).

Top module: `move_elim`

## Requirements
- R1: A request whose read count differs from its write count, or whose count is 0 or 3, is rejected with cause code 1.
- R2: A request with counts 1/1 is a move, and read 0 feeds write 0. A request with counts 2/2 is a swap, and read i feeds write 1-i. When a request is eliminated, each fed destination becomes an alias of its source and the result reports elimination with cause 0.
- R3: Each file accepts at most MAX_ELIM eliminated writes per rename cycle, and 0 means unlimited. A request is rejected with cause 2 when the writes already accepted plus its own write count would exceed the limit. A rejected request consumes no budget.
- R4: A request flagged as first of its rename cycle sees every file's counter at zero.
- R5: The file of write 0 is the request's file. If any used read or write belongs to another file, the request is rejected with cause 3.
- R6: If a fed destination's class forbids elimination, the request is rejected with cause 4.
- R7: If a fed destination is a partial write that does not clear its upper part, the request is rejected with cause 5.
- R8: For a file selected by ZERO_ONLY_MASK, a pair is eliminated only when its source is known zero. Otherwise the request is rejected with cause 6.
- R9: All pairs are checked before any state changes. Any failure leaves every table entry untouched. Cause priority is shape, then budget, then pair 0, then pair 1. Within a pair the order is file, class, partial, zero.
- R10: The alias target is the source's own alias target when the source is an alias, so aliases never chain. If the resolved target equals the destination, the destination holds no alias.
- R11: An eliminated destination takes its source's known-zero bit.
- R12: A plain write clears its destination's alias and sets that register's zero bit to the request's zero-idiom flag. Its result is no elimination with cause 7.
- R13: After reset every entry holds no alias and zero bit 0. `req_ready` is high only in IDLE. The result is valid for one cycle, two cycles after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_first | input | 1 | First request of a rename cycle |
| req_plain | input | 1 | Plain write to write slot 0 |
| req_zero_idiom | input | 1 | Plain write produces zero |
| req_nrd | input | 2 | Read count |
| req_nwr | input | 2 | Write count |
| rd_reg | input | 2×REG_W | Read register indexes |
| rd_file | input | 2×FILE_W | Owning file of each read |
| wr_reg | input | 2×REG_W | Write register indexes |
| wr_file | input | 2×FILE_W | Owning file of each write |
| wr_allow | input | 2 | Write class permits elimination |
| wr_partial | input | 2 | Write is partial and keeps upper part |
| lk_reg | input | REG_W | Table lookup index |
| req_ready | output | 1 | Ready for a request |
| res_valid | output | 1 | Result valid |
| res_elim | output | 1 | Request eliminated |
| res_cause | output | 3 | Outcome code |
| lk_alias_vld | output | 1 | Looked-up register is an alias |
| lk_alias_tgt | output | REG_W | Alias target |
| lk_zero | output | 1 | Looked-up register known zero |

## Verification
The checks drive moves and swaps whose sources are plain registers, aliases and known-zero registers. This separates the crossed swap pairing from a straight one and shows whether an alias chain is collapsed. Rejection cases alter one attribute at a time (count shape, file, class, partial write, zero-only file) and check both the cause code and that the destination's table entry is unchanged. Budget sequences fill a rename cycle with moves and a swap. They show that a swap costs two, that a rejected request costs nothing, and that the first flag restores the budget.

// File: rtl/move_elim_pkg.sv
package move_elim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_DONE = 2'd2
    } me_state_e;

    typedef enum logic [2:0] {
        CA_OK      = 3'd0,
        CA_SHAPE   = 3'd1,
        CA_BUDGET  = 3'd2,
        CA_FILE    = 3'd3,
        CA_CLASS   = 3'd4,
        CA_PARTIAL = 3'd5,
        CA_NONZERO = 3'd6,
        CA_PLAIN   = 3'd7
    } me_cause_e;

endpackage

// File: rtl/move_elim_pair_chk.sv
module move_elim_pair_chk
    import move_elim_pkg::*;
#(
    parameter int FILE_W = 1
) (
    input  logic              active,
    input  logic [FILE_W-1:0] grp_file,
    input  logic [FILE_W-1:0] src_file,
    input  logic [FILE_W-1:0] dst_file,
    input  logic              dst_allow,
    input  logic              dst_partial,
    input  logic              src_zero,
    input  logic              zero_only,
    output logic              pass,
    output me_cause_e         cause
);

    always_comb begin
        cause = CA_OK;
        if (active) begin
            if ((src_file != grp_file) || (dst_file != grp_file)) begin
                cause = CA_FILE;
            end else if (!dst_allow) begin
                cause = CA_CLASS;
            end else if (dst_partial) begin
                cause = CA_PARTIAL;
            end else if (zero_only && !src_zero) begin
                cause = CA_NONZERO;
            end
        end
        pass = (cause == CA_OK);
    end

endmodule

// File: rtl/move_elim_budget.sv
module move_elim_budget #(
    parameter int NUM_FILES = 2,
    parameter int FILE_W    = 1,
    parameter int MAX_ELIM  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_en,
    input  logic              first,
    input  logic [FILE_W-1:0] file,
    input  logic [1:0]        need,
    input  logic              commit,
    output logic              fits
);

    localparam int CNT_W = $clog2(MAX_ELIM + 4);
    localparam int SUM_W = CNT_W + 2;

    logic [CNT_W-1:0] cnt_q [NUM_FILES];
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] eff;
    logic [SUM_W-1:0] sum;

    always_comb begin
        cur = '0;
        for (int f = 0; f < NUM_FILES; f++) begin
            if (int'(file) == f) cur = cnt_q[f];
        end
        eff  = first ? '0 : cur;
        sum  = SUM_W'(eff) + SUM_W'(need);
        fits = (MAX_ELIM == 0) || (sum <= SUM_W'(MAX_ELIM));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int f = 0; f < NUM_FILES; f++) cnt_q[f] <= '0;
        end else if (eval_en) begin
            for (int f = 0; f < NUM_FILES; f++) begin
                if (first) cnt_q[f] <= '0;
                if (commit && (MAX_ELIM != 0) && (int'(file) == f))
                    cnt_q[f] <= sum[CNT_W-1:0];
            end
        end
    end

    for (genvar g = 0; g < NUM_FILES; g++) begin : g_cap
        // R3: a file's accepted count never passes the limit
        a_r3_budget_cap: assert property (@(posedge clk) disable iff (!rst_n)
            (MAX_ELIM == 0) || (int'(cnt_q[g]) <= MAX_ELIM));
    end

endmodule

// File: rtl/move_elim_alias_tbl.sv
module move_elim_alias_tbl #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0][REG_W-1:0] src,
    output logic [1:0][REG_W-1:0] src_tgt,
    output logic [1:0]            src_zero,
    input  logic [1:0]            upd_en,
    input  logic [1:0][REG_W-1:0] upd_dst,
    input  logic                  clr_en,
    input  logic [REG_W-1:0]      clr_reg,
    input  logic                  clr_zero,
    input  logic [REG_W-1:0]      lk_reg,
    output logic                  lk_vld,
    output logic [REG_W-1:0]      lk_tgt,
    output logic                  lk_zero
);

    logic [NUM_REGS-1:0] vld_q;
    logic [NUM_REGS-1:0] zero_q;
    logic [REG_W-1:0]    tgt_q [NUM_REGS];

    for (genvar s = 0; s < 2; s++) begin : g_res
        always_comb begin
            src_tgt[s]  = vld_q[src[s]] ? tgt_q[src[s]] : src[s];
            src_zero[s] = zero_q[src[s]];
        end
    end

    assign lk_vld  = vld_q[lk_reg];
    assign lk_tgt  = tgt_q[lk_reg];
    assign lk_zero = zero_q[lk_reg];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= '0;
            zero_q <= '0;
            for (int r = 0; r < NUM_REGS; r++) tgt_q[r] <= '0;
        end else begin
            if (clr_en) begin
                vld_q[clr_reg]  <= 1'b0;
                zero_q[clr_reg] <= clr_zero;
            end
            for (int s = 0; s < 2; s++) begin
                if (upd_en[s]) begin
                    vld_q[upd_dst[s]]  <= (src_tgt[s] != upd_dst[s]);
                    tgt_q[upd_dst[s]]  <= src_tgt[s];
                    zero_q[upd_dst[s]] <= src_zero[s];
                end
            end
        end
    end

    // R12: a plain write leaves its register without an alias
    a_r12_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !vld_q[$past(clr_reg)]);

    // R11: an eliminated destination inherits the source zero bit
    a_r11_zero_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en[0] && !(upd_en[1] && (upd_dst[1] == upd_dst[0])))
        |=> (zero_q[$past(upd_dst[0])] == $past(src_zero[0])));

    // R10: an eliminated destination never aliases itself
    a_r10_no_self: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en[0] && !upd_en[1])
        |=> !(vld_q[$past(upd_dst[0])] && (tgt_q[$past(upd_dst[0])] == $past(upd_dst[0]))));

endmodule

// File: rtl/move_elim.sv
module move_elim
    import move_elim_pkg::*;
#(
    parameter int                 NUM_REGS       = 16,
    parameter int                 NUM_FILES      = 2,
    parameter int                 MAX_ELIM       = 2,
    parameter logic [NUM_FILES-1:0] ZERO_ONLY_MASK = '0,
    localparam int                REG_W          = $clog2(NUM_REGS),
    localparam int                FILE_W         = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_first,
    input  logic                   req_plain,
    input  logic                   req_zero_idiom,
    input  logic [1:0]             req_nrd,
    input  logic [1:0]             req_nwr,
    input  logic [1:0][REG_W-1:0]  rd_reg,
    input  logic [1:0][FILE_W-1:0] rd_file,
    input  logic [1:0][REG_W-1:0]  wr_reg,
    input  logic [1:0][FILE_W-1:0] wr_file,
    input  logic [1:0]             wr_allow,
    input  logic [1:0]             wr_partial,
    input  logic [REG_W-1:0]       lk_reg,
    output logic                   req_ready,
    output logic                   res_valid,
    output logic                   res_elim,
    output logic [2:0]             res_cause,
    output logic                   lk_alias_vld,
    output logic [REG_W-1:0]       lk_alias_tgt,
    output logic                   lk_zero
);

    me_state_e state_q, state_nx;

    // latched request
    logic                   q_first, q_plain, q_zi;
    logic [1:0]             q_nrd, q_nwr;
    logic [1:0][REG_W-1:0]  q_rd_reg, q_wr_reg;
    logic [1:0][FILE_W-1:0] q_rd_file, q_wr_file;
    logic [1:0]             q_allow, q_partial;

    // evaluation signals
    logic                   shape_ok, two, fits, elim_ok, eval_en;
    logic [FILE_W-1:0]      grp_file;
    logic [1:0]             pair_pass;
    me_cause_e              pair_cause [2];
    me_cause_e              cause_sel;
    logic [1:0][REG_W-1:0]  tbl_src_tgt;
    logic [1:0]             tbl_src_zero;
    logic [1:0]             upd_en;
    logic [1:0][REG_W-1:0]  upd_dst;
    me_cause_e              res_cause_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_nx = ST_EVAL;
            ST_EVAL: state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_first   <= 1'b0;
            q_plain   <= 1'b0;
            q_zi      <= 1'b0;
            q_nrd     <= '0;
            q_nwr     <= '0;
            q_rd_reg  <= '0;
            q_wr_reg  <= '0;
            q_rd_file <= '0;
            q_wr_file <= '0;
            q_allow   <= '0;
            q_partial <= '0;
        end else if ((state_q == ST_IDLE) && req_valid) begin
            q_first   <= req_first;
            q_plain   <= req_plain;
            q_zi      <= req_zero_idiom;
            q_nrd     <= req_nrd;
            q_nwr     <= req_nwr;
            q_rd_reg  <= rd_reg;
            q_wr_reg  <= wr_reg;
            q_rd_file <= rd_file;
            q_wr_file <= wr_file;
            q_allow   <= wr_allow;
            q_partial <= wr_partial;
        end
    end

    assign eval_en  = (state_q == ST_EVAL);
    assign shape_ok = (q_nrd == q_nwr) && (q_nwr != 2'd0) && (q_nwr != 2'd3);
    assign two      = (q_nwr == 2'd2);
    assign grp_file = q_wr_file[0];

    // pair p: read p feeds write (two ? 1-p : 0)
    for (genvar p = 0; p < 2; p++) begin : g_pair
        localparam int ALT = 1 - p;
        logic wsel;
        assign wsel = two ? ALT[0] : 1'b0;

        move_elim_pair_chk #(.FILE_W(FILE_W)) u_chk (
            .active      ((p == 0) || two),
            .grp_file    (grp_file),
            .src_file    (q_rd_file[p]),
            .dst_file    (q_wr_file[wsel]),
            .dst_allow   (q_allow[wsel]),
            .dst_partial (q_partial[wsel]),
            .src_zero    (tbl_src_zero[p]),
            .zero_only   (ZERO_ONLY_MASK[grp_file]),
            .pass        (pair_pass[p]),
            .cause       (pair_cause[p])
        );

        assign upd_dst[p] = q_wr_reg[wsel];
        assign upd_en[p]  = eval_en && elim_ok && ((p == 0) || two);
    end

    always_comb begin
        if (q_plain)           cause_sel = CA_PLAIN;
        else if (!shape_ok)    cause_sel = CA_SHAPE;
        else if (!fits)        cause_sel = CA_BUDGET;
        else if (!pair_pass[0]) cause_sel = pair_cause[0];
        else if (!pair_pass[1]) cause_sel = pair_cause[1];
        else                   cause_sel = CA_OK;
    end

    assign elim_ok = (cause_sel == CA_OK);

    move_elim_budget #(
        .NUM_FILES (NUM_FILES),
        .FILE_W    (FILE_W),
        .MAX_ELIM  (MAX_ELIM)
    ) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .eval_en (eval_en),
        .first   (q_first),
        .file    (grp_file),
        .need    (q_nwr),
        .commit  (elim_ok),
        .fits    (fits)
    );

    move_elim_alias_tbl #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (q_rd_reg),
        .src_tgt  (tbl_src_tgt),
        .src_zero (tbl_src_zero),
        .upd_en   (upd_en),
        .upd_dst  (upd_dst),
        .clr_en   (eval_en && q_plain),
        .clr_reg  (q_wr_reg[0]),
        .clr_zero (q_zi),
        .lk_reg   (lk_reg),
        .lk_vld   (lk_alias_vld),
        .lk_tgt   (lk_alias_tgt),
        .lk_zero  (lk_zero)
    );

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_elim    <= 1'b0;
            res_cause_q <= CA_OK;
        end else if (eval_en) begin
            res_elim    <= elim_ok;
            res_cause_q <= cause_sel;
        end
    end

    assign res_cause = res_cause_q;
    assign res_valid = (state_q == ST_DONE);
    assign req_ready = (state_q == ST_IDLE);

    // R13: result valid lasts exactly one cycle
    a_r13_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R13: no request taken while a result is shown
    a_r13_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready);

    // R13: a result follows two cycles after acceptance
    a_r13_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !res_valid ##1 res_valid);

    // R2: an elimination always reports cause 0
    a_r2_elim_code: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_elim) |-> (res_cause == 3'd0));

    // R1: a mismatched count never updates the table
    a_r1_shape_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && !q_plain && (q_nrd != q_nwr)) |-> (upd_en == 2'b00));

endmodule

// File: tb/move_elim_bench.sv
`timescale 1ns/100ps
module move_elim_bench;

    localparam int REG_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_first = 0, req_plain = 0, req_zero_idiom = 0;
    logic [1:0] req_nrd = 0, req_nwr = 0;
    logic [1:0][REG_W-1:0] rd_reg = '0, wr_reg = '0;
    logic [1:0][0:0] rd_file = '0, wr_file = '0;
    logic [1:0] wr_allow = '0, wr_partial = '0;
    logic [REG_W-1:0] lk_reg = '0;
    logic req_ready, res_valid, res_elim, lk_alias_vld, lk_zero;
    logic [2:0] res_cause;
    logic [REG_W-1:0] lk_alias_tgt;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct { bit elim; logic [2:0] cause; string tag; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    move_elim #(
        .NUM_REGS(16), .NUM_FILES(2), .MAX_ELIM(2), .ZERO_ONLY_MASK(2'b10)
    ) u_move_elim (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_first(req_first),
        .req_plain(req_plain), .req_zero_idiom(req_zero_idiom),
        .req_nrd(req_nrd), .req_nwr(req_nwr), .rd_reg(rd_reg), .rd_file(rd_file),
        .wr_reg(wr_reg), .wr_file(wr_file), .wr_allow(wr_allow), .wr_partial(wr_partial),
        .lk_reg(lk_reg), .req_ready(req_ready), .res_valid(res_valid),
        .res_elim(res_elim), .res_cause(res_cause), .lk_alias_vld(lk_alias_vld),
        .lk_alias_tgt(lk_alias_tgt), .lk_zero(lk_zero)
    );

    // monitor: pops scoreboard on each result
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R13 unexpected result elim=%0d cause=%0d expected none",
                         res_elim, res_cause);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (res_elim !== e.elim || res_cause !== e.cause) begin
                    errors++;
                    $display("FAIL %s elim=%0d cause=%0d expected elim=%0d cause=%0d",
                             e.tag, res_elim, res_cause, e.elim, e.cause);
                end
            end
        end
    end

    task automatic send(bit first, bit plain, bit zi, logic [1:0] nrd, logic [1:0] nwr,
                        logic [3:0] r0, logic [3:0] r1, logic [3:0] w0, logic [3:0] w1,
                        bit rf0, bit rf1, bit wf0, bit wf1,
                        bit a0, bit a1, bit p0, bit p1,
                        bit e, logic [2:0] c, string tag);
        exp_t x;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_first = first; req_plain = plain; req_zero_idiom = zi;
        req_nrd = nrd; req_nwr = nwr;
        rd_reg = {r1, r0}; wr_reg = {w1, w0};
        rd_file = {rf1, rf0}; wr_file = {wf1, wf0};
        wr_allow = {a1, a0}; wr_partial = {p1, p0};
        x.elim = e; x.cause = c; x.tag = tag;
        exp_q.push_back(x);
        @(negedge clk);
        req_valid = 0;
        do @(negedge clk); while (!req_ready);
    endtask

    task automatic mv(bit first, logic [3:0] s, logic [3:0] d, bit f,
                      bit e, logic [2:0] c, string tag);
        send(first, 0, 0, 2'd1, 2'd1, s, 4'd0, d, 4'd0, f, f, f, f, 1, 1, 0, 0, e, c, tag);
    endtask

    task automatic swp(bit first, logic [3:0] r0, logic [3:0] r1, logic [3:0] w0,
                       logic [3:0] w1, bit a1, bit e, logic [2:0] c, string tag);
        send(first, 0, 0, 2'd2, 2'd2, r0, r1, w0, w1, 0, 0, 0, 0, 1, a1, 0, 0, e, c, tag);
    endtask

    task automatic plain(bit first, logic [3:0] d, bit zi, string tag);
        send(first, 1, zi, 2'd1, 2'd1, 4'd0, 4'd0, d, 4'd0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 3'd7, tag);
    endtask

    task automatic chk_lk(logic [3:0] r, bit v, logic [3:0] t, bit z, string tag);
        lk_reg = r;
        #1;
        checks++;
        if (lk_alias_vld !== v || lk_zero !== z || (v && lk_alias_tgt !== t)) begin
            errors++;
            $display("FAIL %s reg%0d vld=%0d tgt=%0d zero=%0d expected vld=%0d tgt=%0d zero=%0d",
                     tag, r, lk_alias_vld, lk_alias_tgt, lk_zero, v, t, z);
        end
    endtask

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            $display("FAIL R13 watchdog expired expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        checks++;
        if (req_ready !== 1'b1 || res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R13 ready=%0d valid=%0d expected 1 0", req_ready, res_valid);
        end
        chk_lk(4'd5, 0, 4'd0, 0, "R13 reset entry");

        // R12 plain zero idiom
        plain(1, 4'd3, 1, "R12 plain zero");
        chk_lk(4'd3, 0, 4'd0, 1, "R12 zero set");

        // R2 move, R11 zero carried
        mv(1, 4'd3, 4'd7, 0, 1, 3'd0, "R2 move");
        chk_lk(4'd7, 1, 4'd3, 1, "R11 move zero");

        // R10 chain collapse
        mv(0, 4'd7, 4'd9, 0, 1, 3'd0, "R10 collapse");
        chk_lk(4'd9, 1, 4'd3, 1, "R10 target");

        // R3 budget full
        mv(0, 4'd1, 4'd2, 0, 0, 3'd2, "R3 budget full");
        chk_lk(4'd2, 0, 4'd0, 0, "R3 no update");

        // R2 crossed swap, R4 first clears
        plain(1, 4'd11, 1, "R12 plain zero r11");
        swp(0, 4'd10, 4'd11, 4'd12, 4'd13, 1, 1, 3'd0, "R4 swap fresh budget");
        chk_lk(4'd12, 1, 4'd11, 1, "R2 write0 from read1");
        chk_lk(4'd13, 1, 4'd10, 0, "R2 write1 from read0");
        mv(0, 4'd1, 4'd2, 0, 0, 3'd2, "R3 swap costs two");

        // R3 rejected request consumes nothing
        mv(1, 4'd1, 4'd2, 0, 1, 3'd0, "R4 move first");
        swp(0, 4'd4, 4'd5, 4'd14, 4'd15, 1, 0, 3'd2, "R3 swap over budget");
        chk_lk(4'd14, 0, 4'd0, 0, "R3 swap untouched");
        mv(0, 4'd1, 4'd4, 0, 1, 3'd0, "R3 reject not consumed");
        chk_lk(4'd4, 1, 4'd1, 0, "R3 second move");

        // R1 shape
        send(1, 0, 0, 2'd1, 2'd2, 4'd1, 4'd2, 4'd6, 4'd8, 0,0,0,0, 1,1,0,0, 0, 3'd1, "R1 mismatch");
        send(1, 0, 0, 2'd0, 2'd0, 4'd1, 4'd2, 4'd6, 4'd8, 0,0,0,0, 1,1,0,0, 0, 3'd1, "R1 zero count");
        send(1, 0, 0, 2'd3, 2'd3, 4'd1, 4'd2, 4'd6, 4'd8, 0,0,0,0, 1,1,0,0, 0, 3'd1, "R1 three");
        chk_lk(4'd6, 0, 4'd0, 0, "R1 untouched");

        // R5 file, R6 class, R7 partial
        send(1, 0, 0, 2'd1, 2'd1, 4'd6, 4'd0, 4'd8, 4'd0, 1,0,0,0, 1,1,0,0, 0, 3'd3, "R5 file");
        send(1, 0, 0, 2'd1, 2'd1, 4'd6, 4'd0, 4'd8, 4'd0, 0,0,0,0, 0,1,0,0, 0, 3'd4, "R6 class");
        send(1, 0, 0, 2'd1, 2'd1, 4'd6, 4'd0, 4'd8, 4'd0, 0,0,0,0, 1,1,1,0, 0, 3'd5, "R7 partial");
        chk_lk(4'd8, 0, 4'd0, 0, "R7 untouched");

        // R9 all-or-nothing swap: read0 feeds write1 which forbids
        swp(1, 4'd1, 4'd2, 4'd14, 4'd15, 0, 0, 3'd4, "R9 swap atomic");
        chk_lk(4'd14, 0, 4'd0, 0, "R9 write0 untouched");
        chk_lk(4'd15, 0, 4'd0, 0, "R9 write1 untouched");

        // R9 shape ahead of budget
        mv(1, 4'd6, 4'd10, 0, 1, 3'd0, "R9 fill one");
        mv(0, 4'd6, 4'd11, 0, 1, 3'd0, "R9 fill two");
        send(0, 0, 0, 2'd2, 2'd1, 4'd1, 4'd2, 4'd5, 4'd8, 0,0,0,0, 1,1,0,0, 0, 3'd1, "R9 shape first");

        // R8 zero-only file 1
        mv(1, 4'd6, 4'd8, 1, 0, 3'd6, "R8 nonzero source");
        chk_lk(4'd8, 0, 4'd0, 0, "R8 untouched");
        plain(1, 4'd6, 1, "R12 zero r6");
        mv(1, 4'd6, 4'd8, 1, 1, 3'd0, "R8 zero source");
        chk_lk(4'd8, 1, 4'd6, 1, "R8 alias");

        // R12 plain non-zero clears alias and zero
        plain(1, 4'd7, 0, "R12 plain clear");
        chk_lk(4'd7, 0, 4'd0, 0, "R12 cleared");

        // R10 target resolves to destination itself
        mv(1, 4'd9, 4'd3, 0, 1, 3'd0, "R10 self move");
        chk_lk(4'd3, 0, 4'd0, 1, "R10 no self alias");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R13 pending=%0d expected 0", exp_q.size());
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule